// File: doc/BRIEF.md
# Value-Copy Reservation Stations with Result Broadcast

This block is the scheduling core of a small out-of-order pipeline that renames registers by copying values. Each instruction handed to it takes a reservation station of its unit type: one integer (ALU) station, one load station, one store station and a parameter-set number of floating-point multiply stations. For each source operand the station receives either the current register-file value or the tag of the station that will produce that value. The destination register's map entry is then pointed at the new station. A zero tag means "value present", so no separate ready bits are kept.

Stations watch a single result bus carrying a (tag, value) pair. They take in matching values, start their built-in fixed-latency unit stub once both operands are present, and then request the bus. On a broadcast the register file and map entry are updated only if the map still names the broadcasting station. Because of this, a younger writer of the same register never has to wait for an older one. Stores drive a store port instead of the bus. Station tags are assigned in a fixed order (1 = ALU, 2 = load, 3 = store, 4 and up = floating point), and this order is also the bus priority.

Top module: `rs_window`

## Requirements
- R1: After reset every station is free, every map tag is 0, register k holds the value k, and `bus_valid`, `st_valid` and `disp_stall` are 0.
- R2: A dispatch whose unit type (0 = ALU, 1 = load, 2 = store, 3 = FP) has no free station raises `disp_stall` in that cycle and changes no station and no map entry; it is accepted in the first cycle a station of that type frees.
- R3: A source whose map tag is 0 is copied from the register file at dispatch.
- R4: An accepted non-store dispatch writes the chosen station's tag into the destination's map entry, with no stall if an older tag is pending there. The lowest free station of the type is chosen: ALU = tag 1, load = 2, store = 3, FP = 4 upward.
- R5: A station issues in the first cycle both source tags are 0. With no waiting, the result reaches the bus 3 cycles after the dispatch cycle for ALU and load, and FP_LAT+2 cycles after for FP.
- R6: A broadcast (tag, value) is taken into every waiting source holding that tag, and it frees the broadcasting station.
- R7: On a broadcast, the register and its map entry are updated (value written, tag cleared) only when the map entry equals the broadcast tag; otherwise both are kept.
- R8: A store does not broadcast. In its writeback cycle it raises `st_valid` with `st_data` = first source and `st_addr` = second source.
- R9: A waiting station issues in the same cycle as the broadcast it waits for, and a station freed by writeback can be allocated in that same cycle.
- R10: When several stations finish together, the lowest tag uses the bus and the others wait for later cycles.
- R11: A dispatch whose source map tag equals the tag on the bus in that same cycle takes the bus value directly.
- R12: ALU opcodes are 0 add, 1 subtract (first minus second), 2 xor, 3 and. A load yields the sum of its sources. FP yields the low DATA_W bits of the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_unit | input | 2 | Unit type: 0 ALU, 1 load, 2 store, 3 FP |
| disp_op | input | 2 | ALU opcode |
| disp_dst | input | $clog2(NREG) | Destination register (ignored for store) |
| disp_src1 | input | $clog2(NREG) | First source register |
| disp_src2 | input | $clog2(NREG) | Second source register |
| disp_stall | output | 1 | Dispatch not accepted this cycle |
| bus_valid | output | 1 | Result bus carries a result |
| bus_tag | output | $clog2(N_FP+4) | Tag of broadcasting station |
| bus_value | output | DATA_W | Broadcast result |
| st_valid | output | 1 | Store writeback |
| st_addr | output | DATA_W | Store address operand |
| st_data | output | DATA_W | Store data operand |
| obs_reg | input | $clog2(NREG) | Register selected for observation |
| obs_value | output | DATA_W | Register-file value of obs_reg |
| obs_tag | output | $clog2(N_FP+4) | Map tag of obs_reg |

## Verification
The bench builds the block with its defaults: 16-bit data, eight registers, two FP stations and a 3-cycle FP stub. With these values the ALU, load and store stations are each single. A second dispatch of the same type therefore hits the stall and the same-cycle reuse directly. The two FP stations make it possible to have two pending writers of one register, which exercises the conditional map update. The short FP latency lets an ALU result and an FP result collide on the bus within a few cycles.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic [1:0] {U_ALU = 2'd0, U_LD = 2'd1, U_ST = 2'd2, U_FP = 2'd3} unit_e;
   typedef enum logic [1:0] {S_FREE, S_WAIT, S_EXEC, S_DONE} sta_state_e;

   function automatic unit_e unit_of(input int idx);
      if (idx == 0) return U_ALU;
      if (idx == 1) return U_LD;
      if (idx == 2) return U_ST;
      return U_FP;
   endfunction
endpackage

// File: rtl/rs_prio.sv
module rs_prio #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   always_comb begin
      gnt = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) gnt = N'(1) << i;
      end
   end
   assign any = |req;
endmodule

// File: rtl/rs_regmap.sv
module rs_regmap #(
   parameter int NREG   = 8,
   parameter int DATA_W = 16,
   parameter int TAG_W  = 3,
   localparam int REG_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_W-1:0]  rs1_i,
   input  logic [REG_W-1:0]  rs2_i,
   output logic [TAG_W-1:0]  t1_o,
   output logic [TAG_W-1:0]  t2_o,
   output logic [DATA_W-1:0] v1_o,
   output logic [DATA_W-1:0] v2_o,
   input  logic [REG_W-1:0]  obs_i,
   output logic [TAG_W-1:0]  obs_t_o,
   output logic [DATA_W-1:0] obs_v_o,
   input  logic              ren_we_i,
   input  logic [REG_W-1:0]  ren_reg_i,
   input  logic [TAG_W-1:0]  ren_tag_i,
   input  logic              wb_valid_i,
   input  logic [REG_W-1:0]  wb_reg_i,
   input  logic [TAG_W-1:0]  wb_tag_i,
   input  logic [DATA_W-1:0] wb_val_i
);
   logic [DATA_W-1:0] rf [NREG];
   logic [TAG_W-1:0]  mp [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NREG; k++) begin
            rf[k] <= DATA_W'(k);
            mp[k] <= '0;
         end
      end else begin
         if (wb_valid_i && mp[wb_reg_i] == wb_tag_i) begin
            rf[wb_reg_i] <= wb_val_i;
            mp[wb_reg_i] <= '0;
         end
         if (ren_we_i) mp[ren_reg_i] <= ren_tag_i;
      end
   end

   assign t1_o    = mp[rs1_i];
   assign t2_o    = mp[rs2_i];
   assign v1_o    = rf[rs1_i];
   assign v2_o    = rf[rs2_i];
   assign obs_t_o = mp[obs_i];
   assign obs_v_o = rf[obs_i];
endmodule

// File: rtl/rs_station.sv
module rs_station #(
   parameter int            DATA_W = 16,
   parameter int            REG_W  = 3,
   parameter int            TAG_W  = 3,
   parameter int            LAT    = 1,
   parameter rs_pkg::unit_e UNIT   = rs_pkg::U_ALU
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic [1:0]        op_i,
   input  logic [REG_W-1:0]  dst_i,
   input  logic [TAG_W-1:0]  t1_i,
   input  logic [TAG_W-1:0]  t2_i,
   input  logic [DATA_W-1:0] v1_i,
   input  logic [DATA_W-1:0] v2_i,
   input  logic              bus_valid_i,
   input  logic [TAG_W-1:0]  bus_tag_i,
   input  logic [DATA_W-1:0] bus_val_i,
   input  logic              grant_i,
   output logic              busy_o,
   output logic              release_o,
   output logic              req_o,
   output logic              st_fire_o,
   output logic [REG_W-1:0]  dst_o,
   output logic [DATA_W-1:0] res_o,
   output logic [DATA_W-1:0] v1_o,
   output logic [DATA_W-1:0] v2_o
);
   import rs_pkg::*;
   localparam int CNT_W = $clog2(LAT + 1);

   if (LAT < 1) begin : g_bad_lat
      $error("rs_station: LAT must be at least 1");
   end

   sta_state_e        state;
   logic [1:0]        op;
   logic [TAG_W-1:0]  t1, t2;
   logic [DATA_W-1:0] v1, v2, res, fu_out;
   logic [CNT_W-1:0]  cnt;
   logic              hit1, hit2, ready;

   assign hit1  = bus_valid_i && (t1 != '0) && (t1 == bus_tag_i);
   assign hit2  = bus_valid_i && (t2 != '0) && (t2 == bus_tag_i);
   assign ready = (state == S_WAIT) && (t1 == '0 || hit1) && (t2 == '0 || hit2);

   // functional-unit stub chosen by unit type
   if (UNIT == U_ALU) begin : g_alu
      always_comb begin
         case (op)
            2'd0:    fu_out = v1 + v2;
            2'd1:    fu_out = v1 - v2;
            2'd2:    fu_out = v1 ^ v2;
            default: fu_out = v1 & v2;
         endcase
      end
   end else if (UNIT == U_FP) begin : g_fp
      logic [2*DATA_W-1:0] prod;
      assign prod   = {{DATA_W{1'b0}}, v1} * {{DATA_W{1'b0}}, v2};
      assign fu_out = prod[DATA_W-1:0];
   end else if (UNIT == U_LD) begin : g_ld
      assign fu_out = v1 + v2;
   end else begin : g_st
      assign fu_out = v1;
   end

   assign req_o     = (state == S_DONE) && (UNIT != U_ST);
   assign st_fire_o = (state == S_DONE) && (UNIT == U_ST);
   assign release_o = st_fire_o || (req_o && grant_i);
   assign busy_o    = (state != S_FREE);
   assign res_o     = res;
   assign v1_o      = v1;
   assign v2_o      = v2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_FREE;
         op    <= '0;
         dst_o <= '0;
         t1    <= '0;
         t2    <= '0;
         v1    <= '0;
         v2    <= '0;
         res   <= '0;
         cnt   <= '0;
      end else begin
         case (state)
            S_WAIT: begin
               if (hit1) begin t1 <= '0; v1 <= bus_val_i; end
               if (hit2) begin t2 <= '0; v2 <= bus_val_i; end
               if (ready) begin
                  state <= S_EXEC;
                  cnt   <= CNT_W'(LAT);
               end
            end
            S_EXEC: begin
               if (cnt == CNT_W'(1)) begin
                  state <= S_DONE;
                  res   <= fu_out;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            S_DONE:  if (release_o) state <= S_FREE;
            default: ;
         endcase
         if (alloc_i) begin
            state <= S_WAIT;
            op    <= op_i;
            dst_o <= dst_i;
            t1    <= t1_i;
            t2    <= t2_i;
            v1    <= v1_i;
            v2    <= v2_i;
         end
      end
   end
endmodule

// File: rtl/rs_window.sv
module rs_window #(
   parameter int DATA_W = 16,
   parameter int NREG   = 8,
   parameter int N_FP   = 2,
   parameter int FP_LAT = 3,
   parameter int ALU_LAT = 1,
   parameter int LD_LAT = 1,
   localparam int NSTA  = 3 + N_FP,
   localparam int TAG_W = $clog2(NSTA + 1),
   localparam int REG_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic [1:0]        disp_unit,
   input  logic [1:0]        disp_op,
   input  logic [REG_W-1:0]  disp_dst,
   input  logic [REG_W-1:0]  disp_src1,
   input  logic [REG_W-1:0]  disp_src2,
   output logic              disp_stall,
   output logic              bus_valid,
   output logic [TAG_W-1:0]  bus_tag,
   output logic [DATA_W-1:0] bus_value,
   output logic              st_valid,
   output logic [DATA_W-1:0] st_addr,
   output logic [DATA_W-1:0] st_data,
   input  logic [REG_W-1:0]  obs_reg,
   output logic [DATA_W-1:0] obs_value,
   output logic [TAG_W-1:0]  obs_tag
);
   import rs_pkg::*;

   if (DATA_W < 4 || NREG < 2 || N_FP < 1 || FP_LAT < 1) begin : g_bad_cfg
      $error("rs_window: DATA_W>=4, NREG>=2, N_FP>=1 and FP_LAT>=1 required");
   end

   logic [NSTA-1:0]   busy, rel, req, stf, type_hit, free_ok, alloc_gnt, bus_gnt;
   logic              alloc_any;
   logic [REG_W-1:0]  s_dst [NSTA];
   logic [DATA_W-1:0] s_res [NSTA];
   logic [DATA_W-1:0] s_v1  [NSTA];
   logic [DATA_W-1:0] s_v2  [NSTA];
   logic [TAG_W-1:0]  m_t1, m_t2, src_t1, src_t2, alloc_tag;
   logic [DATA_W-1:0] m_v1, m_v2, src_v1, src_v2;
   logic [REG_W-1:0]  wb_reg;
   logic              disp_go;

   for (genvar i = 0; i < NSTA; i++) begin : g_sta
      localparam unit_e U   = unit_of(i);
      localparam int    LAT = (U == U_FP) ? FP_LAT : (U == U_LD) ? LD_LAT :
                              (U == U_ALU) ? ALU_LAT : 1;
      assign type_hit[i] = (disp_unit == U);
      assign free_ok[i]  = !busy[i] || rel[i];
      rs_station #(.DATA_W(DATA_W), .REG_W(REG_W), .TAG_W(TAG_W), .LAT(LAT), .UNIT(U)) i_sta (
         .clk(clk), .rst_n(rst_n), .alloc_i(disp_go && alloc_gnt[i]),
         .op_i(disp_op), .dst_i(disp_dst), .t1_i(src_t1), .t2_i(src_t2),
         .v1_i(src_v1), .v2_i(src_v2), .bus_valid_i(bus_valid), .bus_tag_i(bus_tag),
         .bus_val_i(bus_value), .grant_i(bus_gnt[i]), .busy_o(busy[i]),
         .release_o(rel[i]), .req_o(req[i]), .st_fire_o(stf[i]), .dst_o(s_dst[i]),
         .res_o(s_res[i]), .v1_o(s_v1[i]), .v2_o(s_v2[i]));
   end

   rs_prio #(.N(NSTA)) i_alloc (.req(free_ok & type_hit), .gnt(alloc_gnt), .any(alloc_any));
   rs_prio #(.N(NSTA)) i_arb   (.req(req), .gnt(bus_gnt), .any(bus_valid));

   assign disp_go    = disp_valid && alloc_any;
   assign disp_stall = disp_valid && !alloc_any;

   always_comb begin
      alloc_tag = '0;
      bus_tag   = '0;
      bus_value = '0;
      wb_reg    = '0;
      st_valid  = 1'b0;
      st_addr   = '0;
      st_data   = '0;
      for (int i = 0; i < NSTA; i++) begin
         if (alloc_gnt[i]) alloc_tag = TAG_W'(i + 1);
         if (bus_gnt[i]) begin
            bus_tag   = TAG_W'(i + 1);
            bus_value = s_res[i];
            wb_reg    = s_dst[i];
         end
         if (stf[i]) begin
            st_valid = 1'b1;
            st_data  = s_v1[i];
            st_addr  = s_v2[i];
         end
      end
   end

   // source operands: register value, pending tag, or same-cycle bus value
   always_comb begin
      src_t1 = m_t1;
      src_v1 = m_v1;
      src_t2 = m_t2;
      src_v2 = m_v2;
      if (m_t1 != '0) begin
         src_v1 = '0;
         if (bus_valid && bus_tag == m_t1) begin src_t1 = '0; src_v1 = bus_value; end
      end
      if (m_t2 != '0) begin
         src_v2 = '0;
         if (bus_valid && bus_tag == m_t2) begin src_t2 = '0; src_v2 = bus_value; end
      end
   end

   rs_regmap #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_map (
      .clk(clk), .rst_n(rst_n), .rs1_i(disp_src1), .rs2_i(disp_src2),
      .t1_o(m_t1), .t2_o(m_t2), .v1_o(m_v1), .v2_o(m_v2),
      .obs_i(obs_reg), .obs_t_o(obs_tag), .obs_v_o(obs_value),
      .ren_we_i(disp_go && disp_unit != U_ST), .ren_reg_i(disp_dst), .ren_tag_i(alloc_tag),
      .wb_valid_i(bus_valid), .wb_reg_i(wb_reg), .wb_tag_i(bus_tag), .wb_val_i(bus_value));
endmodule

// File: rtl/rs_window_chk.sv
module rs_window_chk #(
   parameter int DATA_W = 16,
   parameter int NREG   = 8,
   parameter int N_FP   = 2,
   localparam int NSTA  = 3 + N_FP,
   localparam int TAG_W = $clog2(NSTA + 1),
   localparam int REG_W = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              disp_valid,
   input logic [1:0]        disp_unit,
   input logic [REG_W-1:0]  disp_dst,
   input logic              disp_stall,
   input logic              bus_valid,
   input logic [TAG_W-1:0]  bus_tag,
   input logic [DATA_W-1:0] bus_value,
   input logic              st_valid,
   input logic [REG_W-1:0]  obs_reg,
   input logic [DATA_W-1:0] obs_value,
   input logic [TAG_W-1:0]  obs_tag
);
   logic accept, renames_obs;
   assign accept      = disp_valid && !disp_stall;
   assign renames_obs = accept && disp_unit != 2'd2 && disp_dst == obs_reg;

   p_alu_busy_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && disp_unit == 2'd0) |=> ((disp_valid && disp_unit == 2'd0) -> disp_stall));

   p_rename_r4: assert property (@(posedge clk) disable iff (!rst_n)
      renames_obs |=> ($stable(obs_reg) -> obs_tag != '0));

   p_bus_tag_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_tag != '0 && int'(bus_tag) <= NSTA));

   p_wb_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && obs_tag == bus_tag && !renames_obs) |=>
      ($stable(obs_reg) -> (obs_value == $past(bus_value) && obs_tag == '0)));

   p_wb_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && obs_tag == bus_tag) |=> ($stable(obs_reg) -> $stable(obs_value)));

   p_store_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> !(bus_valid && bus_tag == TAG_W'(3)));

   p_bus_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> !(bus_valid && bus_tag == $past(bus_tag)));
endmodule

bind rs_window rs_window_chk #(.DATA_W(DATA_W), .NREG(NREG), .N_FP(N_FP)) i_chk (
   .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_unit(disp_unit),
   .disp_dst(disp_dst), .disp_stall(disp_stall), .bus_valid(bus_valid),
   .bus_tag(bus_tag), .bus_value(bus_value), .st_valid(st_valid),
   .obs_reg(obs_reg), .obs_value(obs_value), .obs_tag(obs_tag));

// File: tb/test_rs_window.sv
module test_rs_window;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_valid = 1'b0;
   logic [1:0]  disp_unit = '0, disp_op = '0;
   logic [2:0]  disp_dst = '0, disp_src1 = '0, disp_src2 = '0, obs_reg = '0;
   logic        disp_stall, bus_valid, st_valid;
   logic [2:0]  bus_tag, obs_tag;
   logic [15:0] bus_value, st_addr, st_data, obs_value;
   int          errors = 0, checks = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   rs_window i_rs_window (.*);

   localparam logic [31:0] VEC [6] = '{
      32'h00_2_3_0005, 32'h01_6_1_0005, 32'h01_1_6_FFFB,
      32'h02_5_3_0006, 32'h03_6_3_0002, 32'h00_4_4_0008};

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      disp_valid = 1'b0;
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
   endtask

   task automatic disp(input int unit, input int op, input int dst, input int s1, input int s2);
      disp_valid = 1'b1;
      disp_unit  = 2'(unit);
      disp_op    = 2'(op);
      disp_dst   = 3'(dst);
      disp_src1  = 3'(s1);
      disp_src2  = 3'(s2);
      step(1);
      disp_valid = 1'b0;
   endtask

   task automatic see_bus(input string what, input int tag, input int val);
      chk({what, " bus_valid"}, int'(bus_valid), 1);
      chk({what, " bus_tag"}, int'(bus_tag), tag);
      chk({what, " bus_value"}, int'(bus_value), val);
   endtask

   task automatic see_reg(input string what, input int r, input int val, input int tag);
      obs_reg = 3'(r);
      #0.1;
      chk({what, " reg value"}, int'(obs_value), val);
      chk({what, " reg tag"}, int'(obs_tag), tag);
   endtask

   initial begin
      #(100000 * 5);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      for (int k = 0; k < 8; k++) see_reg("R1 reset", k, k, 0);
      chk("R1 bus idle", int'(bus_valid), 0);
      chk("R1 store idle", int'(st_valid), 0);
      chk("R1 no stall", int'(disp_stall), 0);

      // R12 / R3 / R5: table of ALU ops, result on bus 3 cycles after dispatch
      for (int v = 0; v < 6; v++) begin
         disp(0, int'(VEC[v][31:24]), 7, int'(VEC[v][23:20]), int'(VEC[v][19:16]));
         step(2);
         see_bus("R12 R5 alu vector", 1, int'(VEC[v][15:0]));
         step(1);
         see_reg("R3 R7 alu vector", 7, int'(VEC[v][15:0]), 0);
      end

      // R4: rename points map to ALU station tag 1
      do_reset();
      disp(0, 0, 7, 1, 2);
      see_reg("R4 rename", 7, 7, 1);
      step(2);
      see_bus("R4 alu result", 1, 3);

      // R6 / R9: dependent ALU waits for FP tag 4, issues in broadcast cycle
      do_reset();
      disp(3, 0, 4, 2, 3);
      disp(0, 0, 5, 4, 1);
      step(3);
      see_bus("R6 fp broadcast", 4, 6);
      step(2);
      see_bus("R9 dependent alu", 1, 7);
      step(1);
      see_reg("R6 dependent result", 5, 7, 0);
      see_reg("R6 fp result", 4, 6, 0);

      // R2 / R9: second ALU stalls, then reuses the freed station
      do_reset();
      disp(0, 0, 6, 1, 1);
      disp_valid = 1'b1; disp_unit = 2'd0; disp_op = 2'd2;
      disp_dst = 3'd0; disp_src1 = 3'd2; disp_src2 = 3'd3;
      #0.1;
      chk("R2 stall when busy", int'(disp_stall), 1);
      step(1);
      chk("R2 still stalled", int'(disp_stall), 1);
      see_reg("R2 stalled dispatch leaves map", 0, 0, 0);
      step(1);
      chk("R9 freed station reusable", int'(disp_stall), 0);
      see_bus("R9 writeback same cycle", 1, 2);
      step(1);
      disp_valid = 1'b0;
      see_reg("R2 first op result", 6, 2, 0);
      step(2);
      see_bus("R2 accepted op result", 1, 1);
      step(1);
      see_reg("R2 accepted op reg", 0, 1, 0);

      // R7 / R4: two writers of r3, the older broadcast does not update
      do_reset();
      disp(3, 0, 3, 2, 2);
      disp(3, 0, 3, 1, 1);
      see_reg("R4 second fp station", 3, 3, 5);
      step(3);
      see_bus("R7 older fp", 4, 4);
      step(1);
      see_reg("R7 stale broadcast ignored", 3, 3, 5);
      see_bus("R7 younger fp", 5, 1);
      step(1);
      see_reg("R7 younger updates", 3, 1, 0);

      // R10: ALU and FP finish together, lower tag first
      do_reset();
      disp(3, 0, 4, 2, 3);
      step(1);
      disp(0, 0, 5, 1, 1);
      step(2);
      see_bus("R10 winner tag 1", 1, 2);
      step(1);
      see_bus("R10 loser next cycle", 4, 6);

      // R12: load sums its sources
      do_reset();
      disp(1, 0, 6, 2, 5);
      step(2);
      see_bus("R12 load", 2, 7);
      step(1);
      see_reg("R12 load reg", 6, 7, 0);

      // R8: store drives store port, no broadcast, no rename
      do_reset();
      disp(2, 0, 0, 3, 4);
      see_reg("R8 store no rename", 0, 0, 0);
      step(2);
      chk("R8 st_valid", int'(st_valid), 1);
      chk("R8 st_data", int'(st_data), 3);
      chk("R8 st_addr", int'(st_addr), 4);
      chk("R8 no bus", int'(bus_valid), 0);

      // R11: dispatch reads tag being broadcast in the same cycle
      do_reset();
      disp(3, 0, 4, 2, 2);
      step(4);
      see_bus("R11 fp broadcast", 4, 4);
      disp(0, 0, 5, 4, 1);
      step(2);
      see_bus("R11 captured at dispatch", 1, 5);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule